// File: doc/BRIEF.md
# Oversampling Phase Aligner with Training-Based Lock

The block recovers one serial data channel whose skew against the local receive clock is not known in advance. A front end, modelled here as ideal, delivers every bit period as a vector of `NPH` samples taken at evenly spaced phases of that period. One vector arrives per clock cycle, so one clock cycle is one bit period. Sample 0 is the earliest phase and sample `NPH-1` the latest. Supported phase counts are 4, 5 and 8. The count of 4 corresponds to a front end built from two quadrature clocks, each sampled on both edges, with the block picking one of the four registered sample sets.

After reset, or when retraining is requested, the transmitter sends alternating 0 and 1 bits. For the chosen number of bit periods the block counts, at every boundary between neighbouring samples, how often the data changed there. It then locks onto the sample phase farthest, with wraparound, from the busiest boundary. From then on it emits one recovered bit per period with a valid flag.

A preset mode skips training and loads a phase index measured beforehand on the board. Each instance chooses its phase alone, so skew between channels never affects the lock of any one channel. If the training window shows no transitions, the block reports an error instead of locking.

Top module: `ovs_phase_align`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `locked_o`, `bit_vld_o` and `err_o` are all 0. A start step runs on the first clock edge after release.
- R2: A training window covers L = max(`train_len_i`, 16) bit periods, with `train_len_i` sampled at the start step. The window uses the L vectors presented on the L clock edges that follow the start edge, and the vector at the start edge supplies only the previous last sample. `locked_o` stays 0 until the window has ended.
- R3: Boundary b, for b < NPH-1, lies between samples b and b+1 of the same vector. Boundary NPH-1 lies between the last sample of the previous vector and sample 0 of the current vector. The selected phase is (B + ceil(NPH/2)) mod NPH, where B is the boundary with the most transitions in the window. When several boundaries tie, the lowest index wins.
- R4: `locked_o` rises one cycle after the last training vector, with `phase_o` already holding the selected phase. `phase_o` stays constant while locked.
- R5: While locked and with no retrain request, `bit_vld_o` is 1 in every cycle from the cycle after `locked_o` rose. `bit_o` equals sample `phase_o` of the vector presented one cycle earlier, for every phase, so the bit-period assignment does not depend on the skew.
- R6: If every boundary count is 0 at the end of the window, `err_o` goes to 1 instead of `locked_o`. `bit_vld_o` stays 0, and the error holds until a retrain request, after which `err_o` is 0.
- R7: A retrain request (`retrain_i` = 1 at a clock edge) in any state drives `locked_o` and `bit_vld_o` to 0 in the next cycle and restarts from the start step. It takes priority over training, window end and lock.
- R8: If `preset_en_i` is 1 at the start step, training is skipped. `locked_o` is 1 in the next cycle, with `phase_o` = `preset_phase_i`, or NPH-1 if the value is NPH or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one bit period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_i | input | NPH | Samples of the current bit period, index 0 earliest |
| retrain_i | input | 1 | Restart the phase search |
| preset_en_i | input | 1 | At the start step, load the preset phase instead of training |
| preset_phase_i | input | PW | Preset phase index |
| train_len_i | input | CW | Requested window length in bit periods (minimum 16 applied) |
| bit_o | output | 1 | Recovered bit |
| bit_vld_o | output | 1 | Recovered bit is valid this cycle |
| locked_o | output | 1 | A phase is selected |
| err_o | output | 1 | Training saw no transitions |
| phase_o | output | PW | Selected phase index |

## Verification
Three events can fall in the same cycle: a retrain request, the closing edge of the training window, and a valid output bit while locked. The bench raises `retrain_i` in the cycle where the window ends and the lock decision would be taken, and also in the middle of a locked stream. It judges both cases by valid and lock being low in the next cycle, and by a complete new window of the clamped length being needed before lock returns. Constrained-random training vectors, including random noise with its tie cases, are compared against a histogram model in the bench. Directed vectors cover a two-boundary tie, a window with no transitions and the preset path.

// File: rtl/ovs_pa_pkg.sv
// Shared types for the oversampling phase aligner.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ovs_pa_pkg;

    // Controller states: start step, training window, decision, locked, failed.
    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_TRAIN = 3'd1,
        ST_PICK  = 3'd2,
        ST_LOCK  = 3'd3,
        ST_FAIL  = 3'd4
    } pa_state_e;

endpackage

// File: rtl/ovs_trans_hist.sv
// Transition histogram: one counter per phase boundary.
// Boundary b < NPH-1 sits between samples b and b+1 of one vector.
// Boundary NPH-1 joins the previous vector's last sample to sample 0.
// Assumes: clr_i and acc_i are never high together. Counters saturate.
module ovs_trans_hist #(
    parameter int NPH = 8,
    parameter int CW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              acc_i,
    input  logic [NPH-1:0]    vec_i,
    output logic [NPH*CW-1:0] hist_o
);

    logic             last_q;
    logic [NPH-1:0]   edge_w;
    logic [CW-1:0]    cnt_q [NPH];

    // Keep the last sample of every period for the wrap boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= vec_i[NPH-1];
    end

    genvar b;
    generate
        for (b = 0; b < NPH; b++) begin : g_bnd
            if (b < NPH - 1) begin : g_in
                assign edge_w[b] = vec_i[b] ^ vec_i[b+1];
            end else begin : g_wrap
                assign edge_w[b] = last_q ^ vec_i[0];
            end

            // Count transitions at this boundary during the window.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)                      cnt_q[b] <= '0;
                else if (acc_i && edge_w[b] && ~&cnt_q[b]) cnt_q[b] <= cnt_q[b] + CW'(1);
            end

            assign hist_o[b*CW +: CW] = cnt_q[b];

            // R2: a cleared histogram starts the window from zero.
            a_r2_hist_cleared: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i |=> (cnt_q[b] == '0));
        end
    endgenerate

endmodule

// File: rtl/ovs_phase_pick.sv
// Phase decision: finds the busiest boundary (lowest index on ties) and
// returns the sample phase farthest from it with wraparound.
// Assumes: purely combinational. The result is used only in the decision state.
module ovs_phase_pick #(
    parameter int NPH = 8,
    parameter int CW  = 10,
    localparam int PW = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic [NPH*CW-1:0] hist_i,
    output logic [PW-1:0]     sel_o,
    output logic              none_o
);

    localparam int OFFS = (NPH + 1) / 2;
    localparam int SW   = PW + 1;

    logic [PW-1:0] best_idx;
    logic [CW-1:0] best_val;
    logic [SW-1:0] sum_w;

    // Strict greater-than scan so the lowest index keeps a tie.
    always_comb begin
        best_idx = '0;
        best_val = hist_i[0 +: CW];
        for (int b = 1; b < NPH; b++) begin
            if (hist_i[b*CW +: CW] > best_val) begin
                best_val = hist_i[b*CW +: CW];
                best_idx = PW'(b);
            end
        end
    end

    // Offset by half a period and wrap back into 0..NPH-1.
    always_comb begin
        sum_w = SW'(best_idx) + SW'(OFFS);
        if (sum_w >= SW'(NPH)) sum_w = sum_w - SW'(NPH);
        sel_o  = sum_w[PW-1:0];
        none_o = (best_val == '0);
    end

endmodule

// File: rtl/ovs_pa_ctrl.sv
// Aligner controller: start step, training window counter, decision,
// lock or failure, retrain and preset handling.
// Assumes: retrain_i has priority over every other event.
module ovs_pa_ctrl
    import ovs_pa_pkg::*;
#(
    parameter int NPH       = 8,
    parameter int CW        = 10,
    parameter int MIN_TRAIN = 16,
    localparam int PW = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retrain_i,
    input  logic          preset_en_i,
    input  logic [PW-1:0] preset_phase_i,
    input  logic [CW-1:0] train_len_i,
    input  logic [PW-1:0] pick_sel_i,
    input  logic          pick_none_i,
    output pa_state_e     state_o,
    output logic          clr_o,
    output logic          acc_o,
    output logic [PW-1:0] phase_o
);

    pa_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [PW-1:0] phase_q;
    logic [PW-1:0] preset_ok;

    // Restrict the preset index to legal phases when NPH is not a power of two.
    generate
        if ((1 << PW) == NPH) begin : g_pow2
            assign preset_ok = preset_phase_i;
        end else begin : g_clamp
            assign preset_ok = (preset_phase_i > PW'(NPH - 1)) ? PW'(NPH - 1) : preset_phase_i;
        end
    endgenerate

    // Main state sequence with window counting and phase capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            len_q   <= CW'(MIN_TRAIN);
            phase_q <= '0;
        end else if (retrain_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_START: begin
                    len_q <= (train_len_i < CW'(MIN_TRAIN)) ? CW'(MIN_TRAIN) : train_len_i;
                    cnt_q <= '0;
                    if (preset_en_i) begin
                        state_q <= ST_LOCK;
                        phase_q <= preset_ok;
                    end else begin
                        state_q <= ST_TRAIN;
                    end
                end
                ST_TRAIN: begin
                    if (cnt_q == len_q - CW'(1)) state_q <= ST_PICK;
                    else                          cnt_q   <= cnt_q + CW'(1);
                end
                ST_PICK: begin
                    if (pick_none_i) begin
                        state_q <= ST_FAIL;
                    end else begin
                        state_q <= ST_LOCK;
                        phase_q <= pick_sel_i;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;
    assign clr_o   = (state_q == ST_START);
    assign acc_o   = (state_q == ST_TRAIN);
    assign phase_o = phase_q;

    // R2: the window counter never runs past the sampled length.
    a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIN) |-> (cnt_q < len_q));

    // R4: the selected phase does not move while locked.
    a_r4_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && $past(state_q == ST_LOCK)) |-> $stable(phase_q));

    // R8: preset at the start step locks in the next cycle.
    a_r8_preset_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && preset_en_i && !retrain_i) |=> (state_q == ST_LOCK));

endmodule

// File: rtl/ovs_phase_align.sv
// Oversampling phase aligner, top level. Trains on an alternating pattern,
// locks onto the sample phase farthest from the data transitions and emits
// one recovered bit per clock (one clock = one bit period).
// Assumes: ideal front end giving NPH evenly spaced samples per period;
// NPH is 4, 5 or 8.
module ovs_phase_align
    import ovs_pa_pkg::*;
#(
    parameter int NPH       = 8,
    parameter int CW        = 10,
    parameter int MIN_TRAIN = 16,
    localparam int PW = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] samp_i,
    input  logic           retrain_i,
    input  logic           preset_en_i,
    input  logic [PW-1:0]  preset_phase_i,
    input  logic [CW-1:0]  train_len_i,
    output logic           bit_o,
    output logic           bit_vld_o,
    output logic           locked_o,
    output logic           err_o,
    output logic [PW-1:0]  phase_o
);

    pa_state_e         state_w;
    logic              clr_w;
    logic              acc_w;
    logic [NPH*CW-1:0] hist_w;
    logic [PW-1:0]     sel_w;
    logic              none_w;
    logic [PW-1:0]     phase_w;
    logic              bit_q;
    logic              vld_q;

    ovs_trans_hist #(.NPH(NPH), .CW(CW)) hist_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_w),
        .acc_i  (acc_w),
        .vec_i  (samp_i),
        .hist_o (hist_w)
    );

    ovs_phase_pick #(.NPH(NPH), .CW(CW)) pick_i (
        .hist_i (hist_w),
        .sel_o  (sel_w),
        .none_o (none_w)
    );

    ovs_pa_ctrl #(.NPH(NPH), .CW(CW), .MIN_TRAIN(MIN_TRAIN)) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .retrain_i      (retrain_i),
        .preset_en_i    (preset_en_i),
        .preset_phase_i (preset_phase_i),
        .train_len_i    (train_len_i),
        .pick_sel_i     (sel_w),
        .pick_none_i    (none_w),
        .state_o        (state_w),
        .clr_o          (clr_w),
        .acc_o          (acc_w),
        .phase_o        (phase_w)
    );

    // Register the chosen sample of this period and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            bit_q <= samp_i[phase_w];
            vld_q <= (state_w == ST_LOCK) && !retrain_i;
        end
    end

    assign bit_o     = bit_q;
    assign bit_vld_o = vld_q;
    assign locked_o  = (state_w == ST_LOCK);
    assign err_o     = (state_w == ST_FAIL);
    assign phase_o   = phase_w;

    // R5: no valid bit without lock.
    a_r5_vld_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |-> locked_o);

    // R5: a held lock gives a valid bit every period.
    a_r5_vld_every_period: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && $past(locked_o) && !$past(retrain_i)) |-> bit_vld_o);

    // R6: the error flag excludes lock and valid output.
    a_r6_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!locked_o && !bit_vld_o));

    // R7: a retrain request silences lock and output in the next cycle.
    a_r7_retrain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_i |=> (!locked_o && !bit_vld_o && !err_o));

endmodule

// File: tb/ovs_phase_align_tb_top.sv
`timescale 1ns/1ps
module ovs_phase_align_tb_top;

    localparam int NPH  = 8;
    localparam int CW   = 10;
    localparam int PW   = 3;
    localparam int MINT = 16;
    localparam int OFFS = (NPH + 1) / 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPH-1:0] samp = '0;
    logic           retrain = 1'b0;
    logic           preset_en = 1'b0;
    logic [PW-1:0]  preset_ph = '0;
    logic [CW-1:0]  train_len = CW'(16);
    logic           bit_o, bit_vld, locked, err;
    logic [PW-1:0]  phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_ph = 0;
    logic [NPH-1:0] tv [0:127];

    ovs_phase_align #(.NPH(NPH), .CW(CW), .MIN_TRAIN(MINT)) dut_i (
        .clk(clk), .rst_n(rst_n), .samp_i(samp), .retrain_i(retrain),
        .preset_en_i(preset_en), .preset_phase_i(preset_ph), .train_len_i(train_len),
        .bit_o(bit_o), .bit_vld_o(bit_vld), .locked_o(locked), .err_o(err), .phase_o(phase)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one period, pass the edge, settle away from it.
    task automatic tick(input logic [NPH-1:0] v);
        samp = v;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [NPH-1:0] alt_vec(input int n, input int s);
        logic [NPH-1:0] v;
        for (int k = 0; k < NPH; k++) begin
            int idx = (n * NPH + k + NPH - s) / NPH;
            v[k] = idx[0];
        end
        return v;
    endfunction

    // Expected phase from the bench's own histogram of tv[0..L].
    function automatic int model_pick(input int L, output bit none);
        int h [NPH];
        int best, bv;
        for (int b = 0; b < NPH; b++) h[b] = 0;
        for (int i = 1; i <= L; i++) begin
            for (int b = 0; b < NPH - 1; b++) h[b] += int'(tv[i][b] ^ tv[i][b+1]);
            h[NPH-1] += int'(tv[i-1][NPH-1] ^ tv[i][0]);
        end
        best = 0; bv = h[0];
        for (int b = 1; b < NPH; b++) if (h[b] > bv) begin bv = h[b]; best = b; end
        none = (bv == 0);
        return (best + OFFS) % NPH;
    endfunction

    // Run one training window from the start state and judge the outcome.
    task automatic train_check(input int lreq, input string tag);
        int  leff = (lreq < MINT) ? MINT : lreq;
        bit  none;
        int  e;
        train_len = CW'(lreq);
        tick(tv[0]);
        for (int i = 1; i <= leff; i++) tick(tv[i]);
        chk(!locked && !bit_vld, {"R2 no lock before window end ", tag}, int'(locked), 0);
        e = model_pick(leff, none);
        tick(NPH'($urandom));
        if (none) begin
            chk(err && !locked, {"R6 error without transitions ", tag}, int'(err), 1);
        end else begin
            chk(locked && !err, {"R4 lock after window ", tag}, int'(locked), 1);
            chk(int'(phase) == e, {"R3 selected phase ", tag}, int'(phase), e);
            chk(!bit_vld, {"R4 valid starts one cycle after lock ", tag}, int'(bit_vld), 0);
            exp_ph = e;
        end
    endtask

    // Stream random periods and compare each recovered bit.
    task automatic data_run(input int n, input string tag);
        logic [NPH-1:0] d;
        for (int j = 0; j < n; j++) begin
            d = NPH'($urandom);
            tick(d);
            chk(bit_vld == 1'b1, {"R5 valid each period ", tag}, int'(bit_vld), 1);
            chk(bit_o == d[exp_ph], {"R5 recovered bit ", tag}, int'(bit_o), int'(d[exp_ph]));
        end
    endtask

    task automatic retrain_pulse(input string tag);
        retrain = 1'b1;
        tick(NPH'($urandom));
        retrain = 1'b0;
        chk(!locked && !bit_vld && !err, {"R7 retrain silences outputs ", tag},
            int'({locked, bit_vld, err}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state.
        repeat (3) tick('0);
        chk(!locked && !bit_vld && !err, "R1 reset outputs", int'({locked, bit_vld, err}), 0);
        rst_n = 1'b1;
        #1;
        chk(!locked && !bit_vld && !err, "R1 after release", int'({locked, bit_vld, err}), 0);

        // Directed: skew 3, boundary 2 busiest, phase 6.
        for (int i = 0; i < 128; i++) tv[i] = alt_vec(i, 3);
        train_check(16, "skew3");
        chk(exp_ph == 6, "R3 directed skew3 phase", exp_ph, 6);
        data_run(8, "skew3");

        // R7 inside a locked stream, then a two-boundary tie.
        retrain_pulse("in lock");
        for (int i = 0; i < 128; i++) tv[i] = 8'b0000_1111;
        train_check(20, "tie");
        chk(exp_ph == 7, "R3 tie picks lower boundary", exp_ph, 7);
        data_run(4, "tie");

        // R7 in mid window, then a short length that clamps to 16.
        retrain_pulse("pre mid");
        for (int i = 0; i < 5; i++) tick(alt_vec(i, 5));
        retrain_pulse("mid window");
        for (int i = 0; i < 128; i++) tv[i] = alt_vec(i, 0);
        train_check(5, "clamp");
        chk(exp_ph == 3, "R2 clamped window skew0 phase", exp_ph, 3);
        data_run(3, "clamp");

        // R7 on the window-closing edge: a full new window is needed.
        retrain_pulse("before close");
        train_len = CW'(16);
        for (int i = 0; i <= 16; i++) tick(tv[i]);
        retrain_pulse("at window close");
        tick(tv[0]);
        chk(!locked, "R7 no lock right after restart", int'(locked), 0);
        retrain_pulse("restart again");
        train_check(16, "after close");
        data_run(3, "after close");

        // R6: no transitions, error holds until retrain.
        retrain_pulse("pre err");
        for (int i = 0; i < 128; i++) tv[i] = '0;
        train_check(16, "flat");
        for (int j = 0; j < 3; j++) begin
            tick(NPH'($urandom));
            chk(err && !bit_vld && !locked, "R6 error holds", int'(err), 1);
        end
        retrain_pulse("clear err");
        chk(!err, "R6 error cleared by retrain", int'(err), 0);

        // R8: preset path.
        preset_en = 1'b1;
        preset_ph = 3'd5;
        tick(NPH'($urandom));
        preset_en = 1'b0;
        chk(locked == 1'b1, "R8 preset lock next cycle", int'(locked), 1);
        chk(int'(phase) == 5, "R8 preset phase", int'(phase), 5);
        exp_ph = 5;
        data_run(5, "preset");

        // Constrained random windows: skewed alternation or noise.
        for (int it = 0; it < 12; it++) begin
            int s    = int'($urandom_range(NPH - 1, 0));
            int lreq = int'($urandom_range(60, 8));
            bit noisy = (it % 3 == 2);
            retrain_pulse("rand");
            for (int i = 0; i < 128; i++) tv[i] = noisy ? NPH'($urandom) : alt_vec(i, s);
            train_check(lreq, "rand");
            if (!err) data_run(4, "rand");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule